// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Bank

This block is a byte-wide, synchronous register bank that occupies the eight highest addresses of a 17-bit address space. Every other address reaches a plain byte memory. Inside the clock window, a control byte and seven time bytes (seconds, minutes, hours, day, date, month, year) are visible to software. The visible copies are kept apart from the running time counters, so software can read a consistent snapshot or load a new time while the counters keep moving.

An external 1 Hz pulse advances the counters. A 512 Hz pulse drives the frequency test output. Seconds, minutes and hours roll over in BCD. Day, date, month and year keep the values last loaded. Calendar arithmetic is not part of this block. A power-fail input blocks every access and is reported back on an active-low status pin.

The bus has no back-pressure. An access is a single cycle with `sel` high, and the block always accepts it. Read data appears one cycle later, qualified by `rdata_en`, and the master must take it in that cycle.

Top module: `rtc_regbank`

## Requirements
- R1: Address 0x1FFF8 is the control byte. Addresses 0x1FFF9 to 0x1FFFF are seconds, minutes, hours, day, date, month and year, in that order. Any other address reaches a byte memory indexed by the low `RAM_AW` address bits (default 8). A cycle with `sel` and `we` high writes. A cycle with `sel` high and `we` low reads: in the next cycle `rdata_en` is high when `oe` was high, and `rdata` holds the byte. Otherwise `rdata_en` is 0 and `rdata` is 0.
- R2: When control bits 7 and 6 are both 0, each `tick_1hz` pulse advances the counters and copies the advanced counter fields into the visible bytes in the same cycle.
- R3: Control bit 6 freezes the visible bytes while the counters keep counting. After it clears, the next tick shows the running count.
- R4: Control bit 7 halts refresh. Writing the control byte with bit 7 at 0 while bit 7 is 1 loads every time field from the visible bytes into the counters.
- R5: Seconds bit 7 set to 1 stops the counters. Ticks then have no effect.
- R6: When day bit 6 is 1 and seconds bit 7 is 0, a read of seconds returns in bit 0 a flag that starts at 0 and toggles on each `tick_512` pulse.
- R7: The time field masks are 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x1F and 0xFF, for seconds through year. Bits outside a mask, and control bits 5..0, are plain storage. Seconds and minutes roll from 59 to 00, and hours from 23 to 00, in BCD.
- R8: While `pwr_fail` is high, no write takes effect and reads return `rdata_en` = 0. `pf_out_n` is low in the cycle after `pwr_fail` is seen high, and high otherwise.
- R9: After reset, all registers and counters are 0, `rdata_en` is 0 and `pf_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access strobe |
| oe | input | 1 | Read data output enable |
| we | input | 1 | Write strobe |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the read |
| rdata_en | output | 1 | Read data is driven |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_512 | input | 1 | One-cycle pulse at 512 Hz |
| pwr_fail | input | 1 | Power-fail, blocks access |
| pf_out_n | output | 1 | Power-fail status, active low |

## Verification
The time registers are driven through several patterns, each checked against a behavioural model on every cycle:
- A load of 23:59:58 followed by ticks, which separates a correct BCD carry chain from a binary or missing one.
- Ticks with the read bit held, which shows whether the visible copy froze while the counters kept moving.
- Ticks with the stop bit set, which separates a halted counter from a frozen view.

Writes made during power-fail, reads with `oe` low, and memory addresses just below the clock window (which alias into memory) show whether the access gating and the address decode are correct.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NTIME = 7;
  typedef logic [7:0] byte_t;

  function automatic byte_t field_mask(input int idx);
    case (idx)
      0, 1:    field_mask = 8'h7F;
      2, 4:    field_mask = 8'h3F;
      3:       field_mask = 8'h07;
      5:       field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  function automatic byte_t roll_limit(input int idx);
    roll_limit = (idx == 2) ? 8'h23 : 8'h59;
  endfunction

  function automatic byte_t bcd_step(input byte_t v, input byte_t lim);
    if (v == lim)             bcd_step = 8'h00;
    else if (v[3:0] == 4'h9)  bcd_step = {v[7:4] + 4'h1, 4'h0};
    else                      bcd_step = v + 8'h01;
  endfunction
endpackage

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] a,
  input  logic [7:0]    d,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[a] <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mem[a];
  end
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  run,
  input  logic                  load,
  input  logic [NTIME-1:0][7:0] load_val,
  output logic [NTIME-1:0][7:0] cnt,
  output logic [NTIME-1:0][7:0] cnt_nxt
);
  localparam int NROLL = 3;
  logic [NROLL:0] carry;

  assign carry[0] = tick & run;

  for (genvar i = 0; i < NTIME; i++) begin : g_field
    if (i < NROLL) begin : g_roll
      assign cnt_nxt[i] = carry[i] ? bcd_step(cnt[i], roll_limit(i)) : cnt[i];
      assign carry[i+1] = carry[i] && (cnt[i] == roll_limit(i));
    end else begin : g_hold
      assign cnt_nxt[i] = cnt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt[i] <= '0;
      else if (load) cnt[i] <= load_val[i] & field_mask(i);
      else           cnt[i] <= cnt_nxt[i];
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            widx,
  input  logic [7:0]            wdata,
  input  logic                  tick,
  input  logic [NTIME-1:0][7:0] cnt_nxt,
  output logic [7:0]            ctrl,
  output logic [NTIME-1:0][7:0] vis,
  output logic                  load
);
  logic refresh;

  assign refresh = tick && !ctrl[7] && !ctrl[6];
  assign load    = wr_en && (widx == 3'd0) && ctrl[7] && !wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ctrl <= '0;
    else if (wr_en && widx == 3'd0)  ctrl <= wdata;
  end

  for (genvar i = 0; i < NTIME; i++) begin : g_vis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vis[i] <= '0;
      else if (wr_en && widx == 3'(i + 1))
        vis[i] <= wdata;
      else if (refresh)
        vis[i] <= (vis[i] & ~field_mask(i)) | (cnt_nxt[i] & field_mask(i));
    end
  end

  assert_frozen_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !wr_en) |=> $stable(vis));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              oe,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_en,
  input  logic              tick_1hz,
  input  logic              tick_512,
  input  logic              pwr_fail,
  output logic              pf_out_n
);
  localparam int WIN_W = ADDR_W - 3;

  logic                  acc, wr, rd, in_win;
  logic [2:0]            idx;
  logic [7:0]            ctrl, clk_byte, clk_byte_q, ram_q;
  logic [NTIME-1:0][7:0] vis, cnt, cnt_nxt;
  logic                  load, run, ft_act, ft_q, win_q;

  assign acc    = sel && !pwr_fail;
  assign wr     = acc && we;
  assign rd     = acc && !we;
  assign in_win = (addr[ADDR_W-1:3] == {WIN_W{1'b1}});
  assign idx    = addr[2:0];
  assign run    = !vis[0][7];
  assign ft_act = vis[3][6] && run;

  rtc_byte_ram #(.AW(RAM_AW)) ram_i (
    .clk(clk), .rst_n(rst_n), .wr(wr && !in_win),
    .a(addr[RAM_AW-1:0]), .d(wdata), .q(ram_q)
  );

  rtc_counters cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .run(run), .load(load),
    .load_val(vis), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  rtc_shadow shd_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && in_win), .widx(idx),
    .wdata(wdata), .tick(tick_1hz), .cnt_nxt(cnt_nxt),
    .ctrl(ctrl), .vis(vis), .load(load)
  );

  always_comb begin
    if (idx == 3'd0)      clk_byte = ctrl;
    else if (idx == 3'd1) clk_byte = {vis[0][7:1], ft_act ? ft_q : vis[0][0]};
    else                  clk_byte = vis[idx - 3'd1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_q       <= 1'b0;
      rdata_en   <= 1'b0;
      win_q      <= 1'b0;
      clk_byte_q <= '0;
      pf_out_n   <= 1'b1;
    end else begin
      if (!ft_act)       ft_q <= 1'b0;
      else if (tick_512) ft_q <= !ft_q;
      rdata_en   <= rd && oe;
      win_q      <= in_win;
      clk_byte_q <= clk_byte;
      pf_out_n   <= !pwr_fail;
    end
  end

  assign rdata = !rdata_en ? 8'h00 : (win_q ? clk_byte_q : ram_q);

  assert_read_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !we && oe) |=> !rdata_en);
  assert_pf_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !rdata_en);
  assert_pf_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && !tick_1hz) |=> ($stable(ctrl) && $stable(vis)));
endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, oe = 0, we = 0, tick_1hz = 0, tick_512 = 0, pwr_fail = 0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_en, pf_out_n;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R9";

  always #5 clk = ~clk;

  rtc_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .oe(oe), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .tick_1hz(tick_1hz),
    .tick_512(tick_512), .pwr_fail(pwr_fail), .pf_out_n(pf_out_n)
  );

  // behavioural model
  int vis[7], cnt[7], msk[7];
  int ctrl, ft;
  int mem[int];
  int exp_d, exp_en, exp_pf;

  function automatic int b2i(int v); return (v >> 4) * 10 + (v & 15); endfunction
  function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction

  initial begin
    msk = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    foreach (vis[i]) begin vis[i] = 0; cnt[i] = 0; end
    ctrl = 0; ft = 0; exp_d = 0; exp_en = 0; exp_pf = 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (vis[i]) begin vis[i] = 0; cnt[i] = 0; end
      ctrl = 0; ft = 0; exp_d = 0; exp_en = 0; exp_pf = 1;
    end else begin
      bit a, w, r, win, ftact, ld, rf;
      int ix, rb, s, m, h;
      a = sel && !pwr_fail; w = a && we; r = a && !we;
      win = (addr >= 17'h1FFF8); ix = addr & 7;
      ftact = ((vis[3] >> 6) & 1) && !((vis[0] >> 7) & 1);
      if (win) begin
        if (ix == 0) rb = ctrl;
        else if (ix == 1) rb = ftact ? ((vis[0] & 8'hFE) | ft) : vis[0];
        else rb = vis[ix - 1];
      end else rb = mem.exists(addr & 255) ? mem[addr & 255] : 0;
      exp_en = r && oe; exp_d = exp_en ? rb : 0; exp_pf = !pwr_fail;
      if (!ftact) ft = 0; else if (tick_512) ft ^= 1;
      ld = w && win && ix == 0 && ((ctrl >> 7) & 1) && !((wdata >> 7) & 1);
      rf = tick_1hz && ((ctrl & 8'hC0) == 0);
      if (ld) foreach (cnt[i]) cnt[i] = vis[i] & msk[i];
      else if (tick_1hz && !((vis[0] >> 7) & 1)) begin
        s = b2i(cnt[0]) + 1; m = b2i(cnt[1]); h = b2i(cnt[2]);
        if (s == 60) begin s = 0; m++; if (m == 60) begin m = 0; h = (h + 1) % 24; end end
        cnt[0] = i2b(s); cnt[1] = i2b(m); cnt[2] = i2b(h);
      end
      foreach (vis[i]) begin
        if (w && win && ix == i + 1) vis[i] = wdata;
        else if (rf) vis[i] = (vis[i] & ~msk[i] & 255) | (cnt[i] & msk[i]);
      end
      if (w && win && ix == 0) ctrl = wdata;
      if (w && !win) mem[addr & 255] = wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rdata !== 8'(exp_d) || rdata_en !== 1'(exp_en) || pf_out_n !== 1'(exp_pf)) begin
        fails++;
        $display("FAIL %s: rdata=%h en=%b pf_n=%b expected rdata=%h en=%0d pf_n=%0d",
                 tag, rdata, rdata_en, pf_out_n, exp_d[7:0], exp_en, exp_pf);
      end
    end
  end

  task automatic acc(input bit w, input bit o, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = w; oe = o; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; oe = 0;
  endtask
  task automatic wr(input logic [16:0] a, input logic [7:0] d); acc(1, 0, a, d); endtask
  task automatic rd(input logic [16:0] a); acc(0, 1, a, 8'h00); @(negedge clk); endtask
  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    end
  endtask
  task automatic read_all();
    for (int k = 0; k < 8; k++) rd(17'h1FFF8 + 17'(k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    wr(17'h00010, 8'hA5); wr(17'h1FFF7, 8'h3C); wr(17'h12345, 8'h77);
    rd(17'h00010); rd(17'h000F7); rd(17'h00045);
    acc(0, 0, 17'h00010, 0); @(negedge clk);
    tag = "R2"; tick(3); read_all();
    tag = "R4";
    wr(17'h1FFF8, 8'h80);
    wr(17'h1FFF9, 8'h58); wr(17'h1FFFA, 8'h59); wr(17'h1FFFB, 8'h23);
    wr(17'h1FFFC, 8'h05); wr(17'h1FFFD, 8'h31); wr(17'h1FFFE, 8'h12); wr(17'h1FFFF, 8'h99);
    tick(2); read_all();
    wr(17'h1FFF8, 8'h00);
    tag = "R7"; tick(1); read_all(); tick(1); read_all(); tick(1); read_all();
    tag = "R3"; wr(17'h1FFF8, 8'h40); tick(4); read_all();
    wr(17'h1FFF8, 8'h00); rd(17'h1FFF9); tick(1); read_all();
    tag = "R5"; wr(17'h1FFF9, 8'h80); tick(3); read_all();
    tag = "R6"; wr(17'h1FFF9, 8'h00); wr(17'h1FFFC, 8'h45);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); tick_512 = 1; @(negedge clk); tick_512 = 0;
      rd(17'h1FFF9);
    end
    tick(1); rd(17'h1FFF9);
    tag = "R7"; wr(17'h1FFFE, 8'hE3); wr(17'h1FFF8, 8'h15); wr(17'h1FFFB, 8'hD2);
    tick(1); read_all();
    tag = "R8"; @(negedge clk); pwr_fail = 1;
    wr(17'h00010, 8'h11); wr(17'h1FFF8, 8'h2A); wr(17'h1FFFA, 8'h07);
    rd(17'h00010); rd(17'h1FFF8);
    @(negedge clk); pwr_fail = 0;
    rd(17'h00010); read_all();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule